// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block works next to the instruction decoder of an 8-bit processor. When the decoder has an opcode, it presents an addressing-mode code and pulses `start`. The block then pulls the operand bytes that follow the opcode from the instruction stream, one byte per accepted fetch handshake. For pointer modes it also reads one or two bytes from data memory. It finishes with a one-cycle `done` strobe that carries the 16-bit effective address, or the immediate operand, and the number of instruction bytes it consumed so that the program counter can step past them.

The supported forms are as follows:

- Immediate.
- Direct, short and long.
- Indexed with no offset, a short offset or a long offset. The indexed forms use the X or Y index value chosen by `idx_sel`.
- Pointer-indirect with a byte pointer or a word pointer. In both cases the pointer lives in the first 256 bytes of memory.

The index value and the mode are captured at `start`, so the decoder may change them afterwards without effect. Two-byte fields arrive most significant byte first.

Top module: `operand_ea_seq`

## Requirements
- R1: After reset `busy`, `done`, `fetch_req` and `mem_req` are low, and `ea`, `byte_cnt`, `imm_op` and `no_addr` are zero.
- R2: Mode code 0, and every unused code from 9 to 15, is inherent. It makes no fetch and no read, and raises `done` in the cycle after `start` with `ea`=0, `byte_cnt`=0 and `no_addr`=1.
- R3: Code 1 (immediate) fetches one byte B and finishes with `ea`={8'h00,B}, `imm_op`=1 and `byte_cnt`=1.
- R4: Code 2 (direct short) fetches one byte B and finishes with `ea`={8'h00,B} and `byte_cnt`=1.
- R5: Code 3 (direct long) fetches byte H and then byte L, and finishes with `ea`={H,L} and `byte_cnt`=2.
- R6: Code 4 (indexed, no offset) makes no fetch and finishes in the cycle after `start` with `ea`={8'h00,I} and `byte_cnt`=0. I is `idx_x` when `idx_sel`=0 and `idx_y` when `idx_sel`=1, both sampled at `start`.
- R7: Code 5 (indexed short) fetches an offset byte B and finishes with `ea`=I+B as an unsigned 9-bit sum (at most 0x1FE) and `byte_cnt`=1.
- R8: Code 6 (indexed long) fetches H then L and finishes with `ea`=({H,L}+I) mod 65536 and `byte_cnt`=2.
- R9: Code 7 (indirect short) fetches a pointer byte P and reads data memory at {8'h00,P}. It finishes with `ea`={8'h00,D} and `byte_cnt`=1, where D is the byte read.
- R10: Code 8 (indirect long) fetches P, reads D0 at {8'h00,P} and then D1 at {8'h00,P}+1, computed in 16 bits so that P=0xFF gives 0x0100. It finishes with `ea`={D0,D1} and `byte_cnt`=1.
- R11: A pending `fetch_req` stays high until `fetch_rdy` is seen. A pending `mem_req` holds `mem_addr` steady until `mem_rdy` is seen. The two requests are never high together, and `busy` is high exactly while one of them is pending.
- R12: `done` is a single-cycle pulse in the cycle after the final handshake, with `busy` low. `ea`, `byte_cnt`, `imm_op` and `no_addr` hold until the next `done`. A `start` in the `done` cycle is accepted.
- R13: A `start` while `busy` is high is ignored, and the running sequence completes with the results of its original mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted when not busy) |
| mode | input | 4 | Addressing-mode code |
| idx_sel | input | 1 | 0 selects X, 1 selects Y |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| fetch_req | output | 1 | Requests the next instruction byte |
| fetch_rdy | input | 1 | Instruction byte valid this cycle |
| fetch_byte | input | 8 | Instruction byte |
| mem_req | output | 1 | Data memory read request |
| mem_addr | output | 16 | Data memory read address |
| mem_rdy | input | 1 | Read data valid this cycle |
| mem_data | input | 8 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Effective address or immediate operand |
| byte_cnt | output | 2 | Instruction bytes consumed after the opcode |
| imm_op | output | 1 | `ea` holds an immediate operand |
| no_addr | output | 1 | Mode produced no address |

## Verification
A corrupted step register shows up as a request on the wrong side. A fetch appears where a memory read should be, or the reverse, or `busy` stays high. The bench compares the requests against its model every cycle, so this is seen in the very cycle it happens. A wrong byte register appears only at `done`, as a bad `ea`. To expose such faults, the sequences use ready stalls of random length, index values that change after `start`, and the boundaries 0x1FE, a 16-bit wrap and a pointer at 0xFF.

// File: rtl/operand_ea_seq.sv
module operand_ea_seq #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic            idx_sel,
  input  logic [BW-1:0]   idx_x,
  input  logic [BW-1:0]   idx_y,
  output logic            fetch_req,
  input  logic            fetch_rdy,
  input  logic [BW-1:0]   fetch_byte,
  output logic            mem_req,
  output logic [2*BW-1:0] mem_addr,
  input  logic            mem_rdy,
  input  logic [BW-1:0]   mem_data,
  output logic            busy,
  output logic            done,
  output logic [2*BW-1:0] ea,
  output logic [1:0]      byte_cnt,
  output logic            imm_op,
  output logic            no_addr
);
  localparam int AW = 2 * BW;
  localparam logic [3:0] M_IMM = 4'd1, M_DS = 4'd2, M_DL = 4'd3, M_XN = 4'd4,
                         M_XS = 4'd5, M_XL = 4'd6, M_IS = 4'd7, M_IL = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_F1, S_F2, S_R1, S_R2} st_t;
  st_t st;

  logic [3:0]    md;
  logic [BW-1:0] idx, hi, ptr;

  wire [BW-1:0] idx_in = idx_sel ? idx_y : idx_x;
  wire [AW-1:0] idx_w  = {{BW{1'b0}}, idx};
  wire [AW-1:0] fb_w   = {{BW{1'b0}}, fetch_byte};
  wire [AW-1:0] md_w   = {{BW{1'b0}}, mem_data};

  assign fetch_req = (st == S_F1) || (st == S_F2);
  assign mem_req   = (st == S_R1) || (st == S_R2);
  assign busy      = (st != S_IDLE);
  assign mem_addr  = {{BW{1'b0}}, ptr} + ((st == S_R2) ? AW'(1) : AW'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= '0; idx <= '0; hi <= '0; ptr <= '0;
      done <= 1'b0; ea <= '0; byte_cnt <= '0; imm_op <= 1'b0; no_addr <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          md  <= mode;
          idx <= idx_in;
          case (mode)
            M_IMM, M_DS, M_DL, M_XS, M_XL, M_IS, M_IL: st <= S_F1;
            M_XN: begin
              ea <= {{BW{1'b0}}, idx_in}; byte_cnt <= 2'd0;
              imm_op <= 1'b0; no_addr <= 1'b0; done <= 1'b1;
            end
            default: begin
              ea <= '0; byte_cnt <= 2'd0;
              imm_op <= 1'b0; no_addr <= 1'b1; done <= 1'b1;
            end
          endcase
        end
        S_F1: if (fetch_rdy) begin
          case (md)
            M_IMM, M_DS: begin
              ea <= fb_w; byte_cnt <= 2'd1; imm_op <= (md == M_IMM);
              no_addr <= 1'b0; done <= 1'b1; st <= S_IDLE;
            end
            M_XS: begin
              ea <= idx_w + fb_w; byte_cnt <= 2'd1; imm_op <= 1'b0;
              no_addr <= 1'b0; done <= 1'b1; st <= S_IDLE;
            end
            M_DL, M_XL: begin hi <= fetch_byte; st <= S_F2; end
            M_IS, M_IL: begin ptr <= fetch_byte; st <= S_R1; end
            default: st <= S_IDLE;
          endcase
        end
        S_F2: if (fetch_rdy) begin
          ea <= (md == M_XL) ? ({hi, fetch_byte} + idx_w) : {hi, fetch_byte};
          byte_cnt <= 2'd2; imm_op <= 1'b0; no_addr <= 1'b0;
          done <= 1'b1; st <= S_IDLE;
        end
        S_R1: if (mem_rdy) begin
          if (md == M_IS) begin
            ea <= md_w; byte_cnt <= 2'd1; imm_op <= 1'b0;
            no_addr <= 1'b0; done <= 1'b1; st <= S_IDLE;
          end else begin
            hi <= mem_data; st <= S_R2;
          end
        end
        S_R2: if (mem_rdy) begin
          ea <= {hi, mem_data}; byte_cnt <= 2'd1; imm_op <= 1'b0;
          no_addr <= 1'b0; done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/operand_ea_seq_chk.sv
module operand_ea_seq_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_req,
  input logic            fetch_rdy,
  input logic            mem_req,
  input logic [2*BW-1:0] mem_addr,
  input logic            mem_rdy,
  input logic            busy,
  input logic            done,
  input logic [2*BW-1:0] ea,
  input logic [1:0]      byte_cnt,
  input logic            imm_op,
  input logic            no_addr
);
  p_no_dual_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && mem_req));
  p_busy_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fetch_req || mem_req));
  p_fetch_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_rdy |=> fetch_req);
  p_mem_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr));
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_cnt_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> byte_cnt != 2'd3);
  p_imm_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && imm_op |-> byte_cnt == 2'd1 && ea[2*BW-1:BW] == '0);
  p_noaddr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && no_addr |-> byte_cnt == 2'd0 && ea == '0);
  p_ptr_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr <= (2*BW)'(1 << BW));
endmodule

bind operand_ea_seq operand_ea_seq_chk #(.BW(BW)) u_chk (.*);

// File: tb/sim_operand_ea_seq.sv
module sim_operand_ea_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, idx_sel = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] idx_x = '0, idx_y = '0, fetch_byte = '0, mem_data;
  logic fetch_rdy = 1'b1, mem_rdy = 1'b1;
  logic fetch_req, mem_req, busy, done, imm_op, no_addr;
  logic [15:0] mem_addr, ea;
  logic [1:0] byte_cnt;

  int checks = 0, fails = 0, cycles = 0, stall_pct = 0;
  int feed[$];
  bit hs_pend = 0;

  function automatic int memf(int a);
    return (a * 29 + (a >> 8) * 7 + 5) & 255;
  endfunction
  assign mem_data = 8'(memf(int'(mem_addr)));

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_ea_seq u0 (.*);

  // reference model
  int q[$], got[$];
  int m_mode = 0, m_idx = 0, e_ea = 0, e_cnt = 0;
  bit e_done = 0, e_imm = 0, e_noaddr = 0, ignored = 0, r13_at_done = 0;
  string tag = "R1";

  function automatic string mtag(int m);
    case (m)
      1: return "R3"; 2: return "R4"; 3: return "R5"; 4: return "R6";
      5: return "R7"; 6: return "R8"; 7: return "R9"; 8: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic m_finish();
    e_imm = 0; e_noaddr = 0; e_done = 1;
    case (m_mode)
      1: begin e_ea = got[0]; e_cnt = 1; e_imm = 1; end
      2: begin e_ea = got[0]; e_cnt = 1; end
      3: begin e_ea = got[0] * 256 + got[1]; e_cnt = 2; end
      4: begin e_ea = m_idx; e_cnt = 0; end
      5: begin e_ea = m_idx + got[0]; e_cnt = 1; end
      6: begin e_ea = (got[0] * 256 + got[1] + m_idx) % 65536; e_cnt = 2; end
      7: begin e_ea = got[1]; e_cnt = 1; end
      8: begin e_ea = got[1] * 256 + got[2]; e_cnt = 1; end
      default: begin e_ea = 0; e_cnt = 0; e_noaddr = 1; end
    endcase
    tag = mtag(m_mode);
    r13_at_done = ignored; ignored = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); got.delete(); e_done = 0; e_ea = 0; e_cnt = 0;
      e_imm = 0; e_noaddr = 0; ignored = 0;
    end else begin
      e_done = 0;
      if (q.size() == 0) begin
        if (start) begin
          m_mode = int'(mode);
          m_idx = idx_sel ? int'(idx_y) : int'(idx_x);
          got.delete();
          case (m_mode)
            1, 2, 5: q = '{1};
            3, 6: q = '{1, 1};
            7: q = '{1, 2};
            8: q = '{1, 2, 2};
            default: q.delete();
          endcase
          if (q.size() == 0) m_finish();
        end
      end else begin
        if (start) ignored = 1;
        if (q[0] == 1 && fetch_rdy) begin
          got.push_back(int'(fetch_byte)); void'(q.pop_front());
          if (q.size() == 0) m_finish();
        end else if (q[0] == 2 && mem_rdy) begin
          got.push_back(memf(got[0] + got.size() - 1)); void'(q.pop_front());
          if (q.size() == 0) m_finish();
        end
      end
    end
  end

  task automatic check(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cycles++;
    check("R11", "busy", int'(busy), int'(q.size() != 0));
    check("R11", "fetch_req", int'(fetch_req), int'(q.size() != 0 && q[0] == 1));
    check("R11", "mem_req", int'(mem_req), int'(q.size() != 0 && q[0] == 2));
    if (q.size() != 0 && q[0] == 2)
      check(m_mode == 8 ? "R10" : "R9", "mem_addr", int'(mem_addr), got[0] + got.size() - 1);
    check("R12", "done", int'(done), int'(e_done));
    check(r13_at_done ? "R13" : tag, "ea", int'(ea), e_ea);
    check(tag, "byte_cnt", int'(byte_cnt), e_cnt);
    check(tag, "imm_op", int'(imm_op), int'(e_imm));
    check(tag, "no_addr", int'(no_addr), int'(e_noaddr));
  end

  // instruction stream and ready driver
  always @(negedge clk) begin
    if (hs_pend && feed.size() > 0) void'(feed.pop_front());
    fetch_byte = (feed.size() > 0) ? 8'(feed[0]) : 8'($urandom);
    fetch_rdy  = ($urandom % 100) >= stall_pct;
    mem_rdy    = ($urandom % 100) >= stall_pct;
    hs_pend    = fetch_req && fetch_rdy;
  end

  task automatic op(int m, bit sel, int x, int y, bit extra = 0);
    @(negedge clk);
    start = 1; mode = 4'(m); idx_sel = sel; idx_x = 8'(x); idx_y = 8'(y);
    @(negedge clk);
    start = 0; idx_x = 8'($urandom); idx_y = 8'($urandom); mode = 4'($urandom);
    if (extra && busy) begin
      start = 1; mode = 4'd4;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset fetch_req", int'(fetch_req), 0);
    check("R1", "reset mem_req", int'(mem_req), 0);
    check("R1", "reset ea", int'(ea), 0);
    check("R1", "reset byte_cnt", int'(byte_cnt), 0);
    rst_n = 1;
    op(0, 0, 1, 2);
    op(11, 0, 1, 2);
    feed = '{8'h5A}; op(1, 0, 0, 0);
    feed = '{8'hC3}; op(2, 0, 0, 0);
    feed = '{8'h12, 8'h34}; op(3, 0, 0, 0);
    op(4, 0, 8'h21, 8'h9E);
    op(4, 1, 8'h21, 8'h9E);
    feed = '{8'hFF}; op(5, 1, 8'h00, 8'hFF);
    feed = '{8'hFF, 8'hFF}; op(6, 0, 8'h02, 8'h00);
    feed = '{8'h40}; op(7, 0, 0, 0);
    feed = '{8'hFF}; op(8, 0, 0, 0);
    stall_pct = 50;
    feed = '{8'hAB, 8'hCD}; op(3, 0, 0, 0, 1);
    feed = '{8'h10}; op(8, 1, 0, 0, 1);
    for (int i = 0; i < 400; i++) begin
      stall_pct = (i % 3) * 30;
      op(int'($urandom % 16), 1'($urandom), int'($urandom % 256), int'($urandom % 256), 1'($urandom));
    end
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule